// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a free-running time of day for a precision time protocol engine: a 32-bit count of whole seconds and a 31-bit count of sub-second units. On every advance step a programmable 8-bit increment is added to the sub-second count. When that count passes its largest value it wraps and the seconds count goes up by one. The block can step on every clock (coarse) or only on the carry out of a 32-bit phase accumulator that adds a programmable rate word each clock (fine). The fine mode lets software trim the clock frequency with sub-cycle resolution.

Software drives the block through a simple write port with a 3-bit register select. It can load the time outright, or shift it forward or backward by a signed amount in one step. It can stage a new rate word and commit it with a command. It can arm a comparator that pulses an interrupt once the time reaches a programmed target. The command bits execute one cycle after the control write and then clear themselves. The current time, the live control bits and the trigger state appear on output ports.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time is (0 s, 0), all control bits are 0, and `trig_irq` and `trig_flag` are 0.
- R2: While the run bit (control bit 0) is 0 and no command is pending, the time holds its value.
- R3: In coarse mode (control bit 1 = 0, run = 1) the sub-second count grows by the increment (select 1, bits 7:0) on every clock, starting on the edge after the control write.
- R4: When the sub-second sum reaches 2^31 or more it keeps only its low 31 bits and the seconds count rises by 1.
- R5: In fine mode (control bit 1 = 1) a 32-bit accumulator adds the active rate word each running clock, and the time advances by one increment only on the clocks whose addition carries out of bit 31.
- R6: A rate word written at select 2 is only staged; it becomes active on the edge after a control write with bit 5 set, and bit 5 then reads 0.
- R7: A control write with bit 2 set loads the time from the update seconds (select 3) and update sub-seconds (select 4, bits 30:0) on the next edge, with no count step on that edge; bit 2 then reads 0.
- R8: A control write with bit 3 set adds the update value to the time, treated as one 63-bit quantity (seconds above sub-seconds), or subtracts it when select 4 bit 31 is 1, modulo 2^63; bit 3 then reads 0.
- R9: When bits 2 and 3 are set together, the load wins and the time equals the update value.
- R10: With the arm bit (control bit 4) set, once the time is at or past the target (select 5 seconds, select 6 sub-seconds), `trig_irq` is high for exactly one cycle, `trig_flag` goes to 1, and the arm bit clears.
- R11: With the arm bit clear, passing the target raises no interrupt; a control write with the arm bit set clears `trig_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 increment, 2 rate word, 3 update s, 4 update sub-s and sign, 5 target s, 6 target sub-s |
| cfg_wdata | input | 32 | Write data |
| time_sec | output | 32 | Current seconds |
| time_sub | output | 31 | Current sub-seconds |
| ctl_state | output | 6 | Live control bits: 0 run, 1 fine, 2 load, 3 adjust, 4 arm, 5 rate commit |
| trig_irq | output | 1 | One-cycle pulse when the armed target is reached |
| trig_flag | output | 1 | Sticky trigger status |

## Verification
Coarse counting runs from a mid-range start and from just below the sub-second limit. The first start checks the step size and the one-edge start latency. The second checks the carry into seconds. Fine mode uses a quarter-scale rate word and then a half-scale rate word, each over an eight-cycle window. Before its commit the half-scale word must leave the tick density at one in four, which separates staging from activation. Adjustments are tried with a positive value that carries out of the sub-seconds and with a negative value that borrows from the seconds. The trigger is walked cycle by cycle past the target, both armed and unarmed, which pins the exact firing cycle and the single pulse.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

    localparam int CTL_W    = 6;
    localparam int ARM_BIT  = 4;
    localparam int DATA_W   = 32;

    // Control bits, bit 0 at the bottom.
    typedef struct packed {
        logic rate_commit;  // bit 5
        logic arm;          // bit 4
        logic adjust;       // bit 3
        logic load;         // bit 2
        logic fine;         // bit 1
        logic run;          // bit 0
    } ctl_t;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_INC   = 3'd1,
        SEL_RATE  = 3'd2,
        SEL_USEC  = 3'd3,
        SEL_USUB  = 3'd4,
        SEL_TSEC  = 3'd5,
        SEL_TSUB  = 3'd6
    } sel_e;

endpackage

// File: rtl/ptp_step_gen.sv
module ptp_step_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fine,
    input  logic [ACC_W-1:0] rate,
    output logic             step
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   acc_sum;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, rate};
        acc_d   = acc_q;
        if (run && fine) begin
            acc_d = acc_sum[ACC_W-1:0];
        end
        step = run && (fine ? acc_sum[ACC_W] : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R5: the phase accumulator only moves while running in fine mode
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && fine) |=> $stable(acc_q));

endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic [SEC_W-1:0] now_sec,
    input  logic [SUB_W-1:0] now_sub,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    output logic             reached
);
    localparam int TIME_W = SEC_W + SUB_W;

    logic [TIME_W-1:0] now_t, tgt_t;

    always_comb begin
        now_t   = {now_sec, now_sub};
        tgt_t   = {tgt_sec, tgt_sub};
        reached = (now_t >= tgt_t);
    end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_time_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8,
    parameter int ACC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [SEC_W-1:0]  time_sec,
    output logic [SUB_W-1:0]  time_sub,
    output logic [CTL_W-1:0]  ctl_state,
    output logic              trig_irq,
    output logic              trig_flag
);
    localparam int TIME_W = SEC_W + SUB_W;

    typedef struct packed {
        ctl_t             ctl;
        logic [INC_W-1:0] inc;
        logic [ACC_W-1:0] rate_stage;
        logic [ACC_W-1:0] rate_act;
        logic [SEC_W-1:0] usec;
        logic             usign;
        logic [SUB_W-1:0] usub;
        logic [SEC_W-1:0] tsec;
        logic [SUB_W-1:0] tsub;
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
        logic             irq;
        logic             flag;
    } state_t;

    state_t s_d, s_q;

    logic              step;
    logic              reached;
    logic [TIME_W-1:0] now_t, upd_t;
    logic [SUB_W:0]    sub_sum;

    ptp_step_gen #(.ACC_W(ACC_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.ctl.run),
        .fine  (s_q.ctl.fine),
        .rate  (s_q.rate_act),
        .step  (step)
    );

    ptp_target_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
        .now_sec (s_q.sec),
        .now_sub (s_q.sub),
        .tgt_sec (s_q.tsec),
        .tgt_sub (s_q.tsub),
        .reached (reached)
    );

    always_comb begin
        s_d     = s_q;
        now_t   = {s_q.sec, s_q.sub};
        upd_t   = {s_q.usec, s_q.usub};
        sub_sum = {1'b0, s_q.sub} + (SUB_W+1)'(s_q.inc);

        // Time: load beats adjust, and either beats a count step.
        if (s_q.ctl.load) begin
            {s_d.sec, s_d.sub} = upd_t;
        end else if (s_q.ctl.adjust) begin
            {s_d.sec, s_d.sub} = s_q.usign ? (now_t - upd_t) : (now_t + upd_t);
        end else if (step) begin
            s_d.sub = sub_sum[SUB_W-1:0];
            s_d.sec = s_q.sec + SEC_W'(sub_sum[SUB_W]);
        end
        s_d.ctl.load   = 1'b0;
        s_d.ctl.adjust = 1'b0;

        if (s_q.ctl.rate_commit) begin
            s_d.rate_act        = s_q.rate_stage;
            s_d.ctl.rate_commit = 1'b0;
        end

        s_d.irq = 1'b0;
        if (s_q.ctl.arm && reached) begin
            s_d.irq     = 1'b1;
            s_d.flag    = 1'b1;
            s_d.ctl.arm = 1'b0;
        end

        if (cfg_wr) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    s_d.ctl = ctl_t'(cfg_wdata[CTL_W-1:0]);
                    if (cfg_wdata[ARM_BIT]) begin
                        s_d.flag = s_d.irq;
                    end
                end
                SEL_INC:  s_d.inc        = cfg_wdata[INC_W-1:0];
                SEL_RATE: s_d.rate_stage = cfg_wdata[ACC_W-1:0];
                SEL_USEC: s_d.usec       = cfg_wdata[SEC_W-1:0];
                SEL_USUB: begin
                    s_d.usub  = cfg_wdata[SUB_W-1:0];
                    s_d.usign = cfg_wdata[DATA_W-1];
                end
                SEL_TSEC: s_d.tsec       = cfg_wdata[SEC_W-1:0];
                SEL_TSUB: s_d.tsub       = cfg_wdata[SUB_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign time_sec  = s_q.sec;
    assign time_sub  = s_q.sub;
    assign ctl_state = s_q.ctl;
    assign trig_irq  = s_q.irq;
    assign trig_flag = s_q.flag;

    // R2: idle and no command pending, the time must not move
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctl.run && !s_q.ctl.load && !s_q.ctl.adjust) |=> $stable(now_t));

    // R3: a coarse running cycle advances the joined time by exactly the increment
    p_coarse_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctl.run && !s_q.ctl.fine && !s_q.ctl.load && !s_q.ctl.adjust)
        |=> (now_t == $past(now_t) + TIME_W'($past(s_q.inc))));

    // R7: load and adjust commands clear themselves unless rewritten
    p_cmd_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ctl.load || s_q.ctl.adjust) && !(cfg_wr && cfg_sel == SEL_CTRL))
        |=> !(s_q.ctl.load || s_q.ctl.adjust));

    // R10: the interrupt pulse is a single cycle once disarmed
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_irq && !s_q.ctl.arm) |=> !trig_irq);

    // R10: an interrupt always comes with the sticky flag
    p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> trig_flag);

endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] C_RUN = 32'h01, C_FINE = 32'h02, C_LOAD = 32'h04,
                            C_ADJ = 32'h08, C_ARM = 32'h10, C_RATE = 32'h20;
    localparam logic [31:0] SUB_TOP = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] time_sec;
    logic [30:0] time_sub;
    logic [5:0]  ctl_state;
    logic        trig_irq, trig_flag;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    ptp_time_counter dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .time_sec(time_sec), .time_sub(time_sub),
        .ctl_state(ctl_state), .trig_irq(trig_irq), .trig_flag(trig_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_err++;
                $display("FAIL watchdog: run did not finish");
                $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [62:0] now();
        return {time_sec, time_sub};
    endfunction

    task automatic chk_time(input string tag, input logic [62:0] exp);
        chk(now() == exp, tag, 64'(now()), 64'(exp));
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_time(input logic [31:0] s, input logic [30:0] ss);
        wr(3'd3, s);
        wr(3'd4, {1'b0, ss});
        wr(3'd0, C_LOAD);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_time("R1 time after reset", 63'd0);
        chk(ctl_state == 6'd0, "R1 control after reset", 64'(ctl_state), 64'd0);
        chk(!trig_irq && !trig_flag, "R1 trigger after reset", {62'd0, trig_irq, trig_flag}, 64'd0);
    endtask

    task automatic t_load();
        wr(3'd3, 32'd5);
        wr(3'd4, 32'd100);
        wr(3'd0, C_LOAD);
        chk_time("R7 no change before command edge", 63'd0);
        @(negedge clk);
        chk_time("R7 loaded time", {32'd5, 31'd100});
        chk(ctl_state[2] == 1'b0, "R7 load bit self-clears", 64'(ctl_state), 64'd0);
        repeat (5) @(negedge clk);
        chk_time("R2 time holds while not running", {32'd5, 31'd100});
    endtask

    task automatic t_coarse();
        logic [62:0] t0;
        wr(3'd1, 32'd3);
        wr(3'd0, C_RUN);
        chk_time("R3 first step waits one edge", {32'd5, 31'd100});
        repeat (6) @(negedge clk);
        chk_time("R3 coarse six steps", {32'd5, 31'd118});
        wr(3'd0, 32'd0);
        t0 = now();
        repeat (5) @(negedge clk);
        chk_time("R2 stops after run cleared", t0);
        set_time(32'd7, 31'(SUB_TOP - 32'd2));
        wr(3'd0, C_RUN);
        @(negedge clk);
        chk_time("R4 sub-second wrap carries into seconds", {32'd8, 31'd1});
    endtask

    task automatic t_fine();
        logic [62:0] t0;
        wr(3'd0, 32'd0);
        set_time(32'd0, 31'd0);
        wr(3'd1, 32'd10);
        wr(3'd2, 32'h4000_0000);
        wr(3'd0, C_RATE);
        @(negedge clk);
        chk(ctl_state[5] == 1'b0, "R6 commit bit self-clears", 64'(ctl_state), 64'd0);
        wr(3'd0, C_RUN | C_FINE);
        t0 = now();
        repeat (8) @(negedge clk);
        chk_time("R5 quarter rate gives two steps in eight", t0 + 63'd20);
        wr(3'd2, 32'h8000_0000);
        t0 = now();
        repeat (8) @(negedge clk);
        chk_time("R6 staged rate not yet active", t0 + 63'd20);
        wr(3'd0, C_RUN | C_FINE | C_RATE);
        repeat (2) @(negedge clk);
        t0 = now();
        repeat (8) @(negedge clk);
        chk_time("R6 committed half rate gives four steps", t0 + 63'd40);
        wr(3'd0, 32'd0);
    endtask

    task automatic t_adjust();
        logic [62:0] base, exp;
        set_time(32'd10, 31'(SUB_TOP - 32'd10));
        base = now();
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd50);
        wr(3'd0, C_ADJ);
        @(negedge clk);
        exp = base + {32'd2, 31'd50};
        chk_time("R8 positive adjust with carry", exp);
        chk(exp == {32'd13, 31'd40}, "R8 positive adjust value", 64'(exp), 64'(63'({32'd13, 31'd40})));
        chk(ctl_state[3] == 1'b0, "R8 adjust bit self-clears", 64'(ctl_state), 64'd0);
        wr(3'd3, 32'd1);
        wr(3'd4, 32'h8000_0064);
        wr(3'd0, C_ADJ);
        @(negedge clk);
        chk_time("R8 negative adjust with borrow", {32'd11, 31'(SUB_TOP - 32'd60)});
        wr(3'd3, 32'd100);
        wr(3'd4, 32'd0);
        wr(3'd0, C_LOAD | C_ADJ);
        @(negedge clk);
        chk_time("R9 load wins over adjust", {32'd100, 31'd0});
        chk(ctl_state[3:2] == 2'b00, "R9 both command bits clear", 64'(ctl_state), 64'd0);
    endtask

    task automatic t_trigger();
        int hits;
        set_time(32'd0, 31'd0);
        wr(3'd1, 32'd3);
        wr(3'd5, 32'd0);
        wr(3'd6, 32'd30);
        wr(3'd0, C_RUN | C_ARM);
        hits = 0;
        for (int j = 1; j <= 16; j++) begin
            @(negedge clk);
            if (trig_irq) hits++;
            if (j == 11) chk(trig_irq, "R10 interrupt on first cycle at target", 64'(trig_irq), 64'd1);
        end
        chk(hits == 1, "R10 exactly one pulse", 64'(hits), 64'd1);
        chk(trig_flag, "R10 flag set", 64'(trig_flag), 64'd1);
        chk(ctl_state[4] == 1'b0, "R10 arm bit clears", 64'(ctl_state), 64'd0);
        wr(3'd5, 32'd50);
        wr(3'd0, C_RUN | C_ARM);
        chk(!trig_flag, "R11 arming clears flag", 64'(trig_flag), 64'd0);
        set_time(32'd0, 31'd0);
        wr(3'd5, 32'd0);
        wr(3'd0, C_RUN);
        hits = 0;
        for (int j = 1; j <= 16; j++) begin
            @(negedge clk);
            if (trig_irq) hits++;
        end
        chk(hits == 0, "R11 no interrupt when unarmed", 64'(hits), 64'd0);
        chk(!trig_flag, "R11 flag stays clear when unarmed", 64'(trig_flag), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_coarse();
        t_fine();
        t_adjust();
        t_trigger();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule